// File: doc/BRIEF.md
# Dual-Channel DAC Trigger and Triangle Controller

This block is the digital control path in front of a two-channel 12-bit converter. Each channel keeps a held sample and an output sample. In direct mode the output copies the held sample on the next clock. In triggered mode the output is loaded only after a trigger event: a rising edge on the selected line of a shared eight-line trigger bus, or a per-channel software strobe. The output is loaded a fixed three cycles after that event.

A channel in triggered mode can also add an internal up/down triangle counter to the held sample before the transfer. Each channel has its own triangle amplitude. The counter moves one step after every transfer. Held samples are written for both channels at once through one 32-bit word in one of three packings. Per-channel settings are written one channel at a time through a small configuration port.

Top module: `twin_dac_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become 0, both held samples become 0 and every channel setting clears, which selects direct mode. Outputs stay 0 until a held-sample write.
- R2: With `cfg_trig_en` = 0 for a channel, its output equals the held sample one clock after the edge that wrote the held sample, and not at that edge.
- R3: A held-sample write decodes `hold_word` by `hold_fmt`. Code 0 gives channel 0 = bits 11:0 and channel 1 = bits 27:16. Code 1 gives channel 0 = bits 15:4 and channel 1 = bits 31:20. Code 2 gives channel 0 = {bits 7:0, 4'h0} and channel 1 = {bits 15:8, 4'h0}. Code 3 changes nothing.
- R4: With `cfg_trig_en` = 1, a trigger event sampled at edge T makes the output change at edge T+3 and not before. The new value is the held sample as it was at edge T, plus the counter when triangle mode is on. Between transfers the output holds its value.
- R5: `sw_trig[c]` high at an edge is a trigger event for channel c only, whatever its source select is.
- R6: Trigger lines are edge-detected: a line held high gives one event. An event that arrives while the channel's three-cycle transfer is still pending is ignored.
- R7: Channels whose `cfg_src` values are equal both take the same edge of `trig_in` and update at the same edge. A channel whose source differs is not affected.
- R8: When wave field bit 1 is set, the added counter starts at 0. It steps up by one per transfer to 2^(amp+1)-1, then down by one to 0, and repeats.
- R9: Amplitude codes 12 to 15 act as code 11 (peak 4095).
- R10: The held sample plus the counter wraps modulo 4096.
- R11: Clearing the trigger enable or clearing wave bit 1 returns that channel's counter to 0.
- R12: Wave field values 00 and 01 add nothing to the held sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for channel settings |
| cfg_sel | input | 1 | Channel addressed by the settings write |
| cfg_trig_en | input | 1 | 1 = triggered mode, 0 = direct mode |
| cfg_src | input | 3 | Index of the trigger line for the channel |
| cfg_wave | input | 2 | Wave field; bit 1 set selects the triangle |
| cfg_amp | input | 4 | Triangle amplitude code |
| hold_we | input | 1 | Write strobe for both held samples |
| hold_fmt | input | 2 | Packing of `hold_word` (see R3) |
| hold_word | input | 32 | Packed held-sample data for both channels |
| trig_in | input | 8 | Shared trigger lines, rising-edge active |
| sw_trig | input | 2 | Per-channel software trigger strobes |
| dout0 | output | 12 | Channel 0 output sample |
| dout1 | output | 12 | Channel 1 output sample |

## Verification
The assertions check three things on every cycle: both outputs clear after reset, a direct-mode channel copies its held sample with one cycle of delay, and a triggered-mode output stays frozen except on the edge that ends a pending transfer. The triangle sequence, the amplitude clamp, the modulo-4096 wrap, the counter clear and the rejection of events during a pending transfer can only be seen through the bench's trigger scenarios. The same holds for shared versus separate trigger sources and for the three data packings.

// File: rtl/twin_dac_pkg.sv
package twin_dac_pkg;

    localparam int DAC_W   = 12;
    localparam int NUM_CH  = 2;
    localparam int TRIG_N  = 8;
    localparam int SEL_W   = $clog2(TRIG_N);
    localparam int AMP_W   = 4;
    localparam int AMP_CAP = 11;

    typedef logic [DAC_W-1:0] sample_t;

    typedef enum logic [1:0] {
        FMT_R12  = 2'd0,
        FMT_L12  = 2'd1,
        FMT_R8   = 2'd2,
        FMT_NONE = 2'd3
    } fmt_e;

    typedef struct packed {
        logic             trig_en;
        logic [SEL_W-1:0] src;
        logic [1:0]       wave;
        logic [AMP_W-1:0] amp;
    } lane_cfg_t;

    // Turning point of the triangle for an amplitude code, clamped at AMP_CAP.
    function automatic sample_t tri_peak(input logic [AMP_W-1:0] amp);
        logic [AMP_W-1:0] c;
        c = (amp > AMP_W'(AMP_CAP)) ? AMP_W'(AMP_CAP) : amp;
        return sample_t'((32'd1 << (32'(c) + 32'd1)) - 32'd1);
    endfunction

    // Extracts one channel's held sample from a packed dual-channel word.
    function automatic sample_t unpack_word(input fmt_e fmt, input logic [31:0] w,
                                            input logic ch);
        case (fmt)
            FMT_R12: return ch ? w[27:16] : w[11:0];
            FMT_L12: return ch ? w[31:20] : w[15:4];
            default: return ch ? {w[15:8], 4'h0} : {w[7:0], 4'h0};
        endcase
    endfunction

endpackage

// File: rtl/twin_dac_edge.sv
module twin_dac_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/twin_dac_tri.sv
module twin_dac_tri
    import twin_dac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [AMP_W-1:0] amp,
    output sample_t          count
);
    sample_t cnt_q;
    logic    down_q;
    sample_t peak;

    assign peak  = tri_peak(amp);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (step) begin
            if (!down_q) begin
                if (cnt_q >= peak) begin
                    down_q <= 1'b1;
                    cnt_q  <= cnt_q - sample_t'(1);
                end else begin
                    cnt_q  <= cnt_q + sample_t'(1);
                end
            end else begin
                if (cnt_q == '0) begin
                    down_q <= 1'b0;
                    cnt_q  <= cnt_q + sample_t'(1);
                end else begin
                    cnt_q  <= cnt_q - sample_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/twin_dac_lane.sv
module twin_dac_lane
    import twin_dac_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  lane_cfg_t         cfg_in,
    input  logic              hold_we,
    input  sample_t           hold_in,
    input  logic [TRIG_N-1:0] rise,
    input  logic              sw,
    output sample_t           dout
);
    localparam int PW = $clog2(LAT + 1);

    lane_cfg_t       cfg_q;
    sample_t         hold_q;
    sample_t         stage_q;
    sample_t         dout_q;
    sample_t         tri_cnt;
    logic [PW-1:0]   pend_q;
    logic            tri_on;
    logic            fire;
    logic            land;

    assign tri_on = cfg_q.trig_en && cfg_q.wave[1];
    assign fire   = cfg_q.trig_en && (pend_q == '0) && (rise[cfg_q.src] || sw);
    assign land   = cfg_q.trig_en && (pend_q == PW'(1));
    assign dout   = dout_q;

    twin_dac_tri u_tri (
        .clk   (clk),
        .rst   (rst),
        .clear (~tri_on),
        .step  (land && tri_on),
        .amp   (cfg_q.amp),
        .count (tri_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            hold_q  <= '0;
            stage_q <= '0;
            dout_q  <= '0;
            pend_q  <= '0;
        end else begin
            if (cfg_we)  cfg_q  <= cfg_in;
            if (hold_we) hold_q <= hold_in;
            if (!cfg_q.trig_en) begin
                pend_q <= '0;
                dout_q <= hold_q;
            end else begin
                if (fire) begin
                    pend_q  <= PW'(LAT);
                    stage_q <= hold_q + (tri_on ? tri_cnt : sample_t'(0));
                end else if (pend_q != '0) begin
                    pend_q  <= pend_q - PW'(1);
                end
                if (land) dout_q <= stage_q;
            end
        end
    end
endmodule

// File: rtl/twin_dac_ctrl.sv
module twin_dac_ctrl
    import twin_dac_pkg::*;
#(
    parameter int XFER_LAT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic        cfg_trig_en,
    input  logic [2:0]  cfg_src,
    input  logic [1:0]  cfg_wave,
    input  logic [3:0]  cfg_amp,
    input  logic        hold_we,
    input  logic [1:0]  hold_fmt,
    input  logic [31:0] hold_word,
    input  logic [7:0]  trig_in,
    input  logic [1:0]  sw_trig,
    output logic [11:0] dout0,
    output logic [11:0] dout1
);
    logic [TRIG_N-1:0] rise;
    lane_cfg_t         cfg_word;
    logic              hold_ok;
    sample_t           lane_out [NUM_CH];

    assign cfg_word = '{trig_en: cfg_trig_en, src: cfg_src, wave: cfg_wave, amp: cfg_amp};
    assign hold_ok  = hold_we && (fmt_e'(hold_fmt) != FMT_NONE);

    twin_dac_edge #(.N(TRIG_N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (trig_in),
        .rise (rise)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        twin_dac_lane #(.LAT(XFER_LAT)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .cfg_we  (cfg_we && (cfg_sel == 1'(ch))),
            .cfg_in  (cfg_word),
            .hold_we (hold_ok),
            .hold_in (unpack_word(fmt_e'(hold_fmt), hold_word, 1'(ch))),
            .rise    (rise),
            .sw      (sw_trig[ch]),
            .dout    (lane_out[ch])
        );
    end

    assign dout0 = lane_out[0];
    assign dout1 = lane_out[1];
endmodule

// File: rtl/twin_dac_chk.sv
module twin_dac_chk
    import twin_dac_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic        cfg_trig_en,
    input  logic [2:0]  cfg_src,
    input  logic        hold_we,
    input  logic [1:0]  hold_fmt,
    input  logic [31:0] hold_word,
    input  logic [7:0]  trig_in,
    input  logic [1:0]  sw_trig,
    input  logic [11:0] dout0,
    input  logic [11:0] dout1
);
    localparam int PW = $clog2(LAT + 1);

    logic [1:0]    en_q;
    logic [2:0]    src_q  [2];
    sample_t       hold_q [2];
    logic [PW-1:0] pend_q [2];
    logic [7:0]    prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            prev_q <= '0;
            for (int c = 0; c < 2; c++) begin
                src_q[c]  <= '0;
                hold_q[c] <= '0;
                pend_q[c] <= '0;
            end
        end else begin
            prev_q <= trig_in;
            for (int c = 0; c < 2; c++) begin
                if (cfg_we && cfg_sel == 1'(c)) begin
                    en_q[c]  <= cfg_trig_en;
                    src_q[c] <= cfg_src;
                end
                if (hold_we && hold_fmt != 2'd3)
                    hold_q[c] <= unpack_word(fmt_e'(hold_fmt), hold_word, 1'(c));
                if (!en_q[c])
                    pend_q[c] <= '0;
                else if (pend_q[c] != '0)
                    pend_q[c] <= pend_q[c] - PW'(1);
                else if ((trig_in[src_q[c]] && !prev_q[src_q[c]]) || sw_trig[c])
                    pend_q[c] <= PW'(LAT);
            end
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (dout0 == '0 && dout1 == '0));

    assert_direct_ch0_R2: assert property (@(posedge clk) disable iff (rst)
        !en_q[0] |=> dout0 == $past(hold_q[0]));

    assert_direct_ch1_R2: assert property (@(posedge clk) disable iff (rst)
        !en_q[1] |=> dout1 == $past(hold_q[1]));

    assert_hold_between_ch0_R4: assert property (@(posedge clk) disable iff (rst)
        (en_q[0] && pend_q[0] != PW'(1)) |=> $stable(dout0));

    assert_hold_between_ch1_R4: assert property (@(posedge clk) disable iff (rst)
        (en_q[1] && pend_q[1] != PW'(1)) |=> $stable(dout1));
endmodule

bind twin_dac_ctrl twin_dac_chk #(.LAT(XFER_LAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_trig_en (cfg_trig_en),
    .cfg_src     (cfg_src),
    .hold_we     (hold_we),
    .hold_fmt    (hold_fmt),
    .hold_word   (hold_word),
    .trig_in     (trig_in),
    .sw_trig     (sw_trig),
    .dout0       (dout0),
    .dout1       (dout1)
);

// File: tb/tb_twin_dac_ctrl.sv
module tb_twin_dac_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_trig_en = 1'b0;
    logic [2:0]  cfg_src = '0;
    logic [1:0]  cfg_wave = '0;
    logic [3:0]  cfg_amp = '0;
    logic        hold_we = 1'b0;
    logic [1:0]  hold_fmt = '0;
    logic [31:0] hold_word = '0;
    logic [7:0]  trig_in = '0;
    logic [1:0]  sw_trig = '0;
    logic [11:0] dout0;
    logic [11:0] dout1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    twin_dac_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_trig_en(cfg_trig_en), .cfg_src(cfg_src), .cfg_wave(cfg_wave),
        .cfg_amp(cfg_amp), .hold_we(hold_we), .hold_fmt(hold_fmt),
        .hold_word(hold_word), .trig_in(trig_in), .sw_trig(sw_trig),
        .dout0(dout0), .dout1(dout1)
    );

    typedef struct packed {
        logic [1:0]  fmt;
        logic [31:0] word;
        logic [11:0] e0;
        logic [11:0] e1;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 32'h0ABC_0123, 12'h123, 12'hABC},
        '{2'd1, 32'hFED0_1230, 12'h123, 12'hFED},
        '{2'd2, 32'h0000_A55A, 12'h5A0, 12'hA50},
        '{2'd3, 32'hFFFF_FFFF, 12'h5A0, 12'hA50},
        '{2'd0, 32'hF001_FFFF, 12'hFFF, 12'h001},
        '{2'd1, 32'h000F_FFF0, 12'hFFF, 12'h000}
    };

    localparam int TRI1 [10] = '{0, 1, 2, 3, 2, 1, 0, 1, 2, 3};

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cfg(input logic ch, input logic en, input logic [2:0] src,
                       input logic [1:0] wave, input logic [3:0] amp);
        cfg_we = 1'b1; cfg_sel = ch; cfg_trig_en = en;
        cfg_src = src; cfg_wave = wave; cfg_amp = amp;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic write_hold(input logic [1:0] fmt, input logic [31:0] w);
        hold_we = 1'b1; hold_fmt = fmt; hold_word = w;
        step();
        hold_we = 1'b0;
    endtask

    // Event sampled at edge T; returns after edge T+3.
    task automatic fire(input logic [7:0] t, input logic [1:0] s);
        trig_in = t; sw_trig = s;
        step();
        trig_in = '0; sw_trig = '0;
        step(); step(); step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] p0;
        logic [11:0] p1;
        repeat (3) step();
        rst = 1'b0;
        chk("R1 reset dout0", dout0, 12'h000);
        chk("R1 reset dout1", dout1, 12'h000);

        // R2 / R3: packing table in direct mode
        p0 = '0; p1 = '0;
        for (int i = 0; i < 6; i++) begin
            hold_we = 1'b1; hold_fmt = VECS[i].fmt; hold_word = VECS[i].word;
            step();
            hold_we = 1'b0;
            chk("R2 not at write edge ch0", dout0, p0);
            chk("R2 not at write edge ch1", dout1, p1);
            step();
            chk("R3 decode ch0", dout0, VECS[i].e0);
            chk("R3 decode ch1", dout1, VECS[i].e1);
            p0 = VECS[i].e0; p1 = VECS[i].e1;
        end

        // R4 latency
        write_hold(2'd0, 32'h0200_0100);
        cfg(1'b0, 1'b1, 3'd3, 2'b00, 4'd0);
        write_hold(2'd0, 32'h0222_0111);
        step();
        chk("R4 triggered mode ignores hold write", dout0, 12'h100);
        chk("R2 direct ch1 follows", dout1, 12'h222);
        trig_in = 8'h08;
        step();
        trig_in = '0;
        chk("R4 T+0", dout0, 12'h100);
        step(); chk("R4 T+1", dout0, 12'h100);
        step(); chk("R4 T+2", dout0, 12'h100);
        step(); chk("R4 T+3", dout0, 12'h111);

        // R6 held-high line and retrigger while pending
        write_hold(2'd0, 32'h0222_0155);
        trig_in = 8'h08;
        step(); step(); step(); step();
        chk("R6 first edge lands", dout0, 12'h155);
        write_hold(2'd0, 32'h0222_0166);
        step(); step(); step(); step();
        chk("R6 held high gives one event", dout0, 12'h155);
        trig_in = '0;
        step();
        trig_in = 8'h08;
        step();
        trig_in = '0; hold_we = 1'b1; hold_fmt = 2'd0; hold_word = 32'h0222_0177;
        step();
        hold_we = 1'b0; trig_in = 8'h08;
        step();
        trig_in = '0;
        step();
        chk("R6 retrigger lands held value", dout0, 12'h166);
        step(); step(); step(); step();
        chk("R6 event during pending ignored", dout0, 12'h166);
        fire(8'h08, 2'b00);
        chk("R4 next event", dout0, 12'h177);

        // R5 software strobe
        cfg(1'b1, 1'b1, 3'd6, 2'b00, 4'd0);
        write_hold(2'd0, 32'h0333_0177);
        fire(8'h00, 2'b10);
        chk("R5 sw ch1", dout1, 12'h333);
        chk("R5 sw leaves ch0", dout0, 12'h177);

        // R7 shared and separate sources
        cfg(1'b0, 1'b1, 3'd5, 2'b00, 4'd0);
        cfg(1'b1, 1'b1, 3'd5, 2'b00, 4'd0);
        write_hold(2'd0, 32'h0444_0188);
        fire(8'h20, 2'b00);
        chk("R7 shared ch0", dout0, 12'h188);
        chk("R7 shared ch1", dout1, 12'h444);
        cfg(1'b1, 1'b1, 3'd2, 2'b00, 4'd0);
        write_hold(2'd0, 32'h0455_0199);
        fire(8'h20, 2'b00);
        chk("R7 separate ch0 moves", dout0, 12'h199);
        chk("R7 separate ch1 stays", dout1, 12'h444);
        fire(8'h04, 2'b00);
        chk("R7 own line ch1", dout1, 12'h455);
        chk("R7 own line ch0 stays", dout0, 12'h199);

        // R8 triangle, amplitude code 1 (peak 3)
        cfg(1'b0, 1'b1, 3'd5, 2'b10, 4'd1);
        write_hold(2'd0, 32'h0455_0064);
        for (int k = 0; k < 10; k++) begin
            fire(8'h20, 2'b00);
            chk("R8 triangle step", dout0, 12'(12'h064 + TRI1[k]));
        end

        // R11 / R12 counter clear and non-triangle wave codes
        cfg(1'b0, 1'b1, 3'd5, 2'b00, 4'd1);
        fire(8'h20, 2'b00);
        chk("R12 wave 00 adds nothing", dout0, 12'h064);
        cfg(1'b0, 1'b1, 3'd5, 2'b10, 4'd1);
        fire(8'h20, 2'b00);
        chk("R11 wave off clears counter", dout0, 12'h064);
        fire(8'h20, 2'b00);
        chk("R8 counter advances", dout0, 12'h065);
        cfg(1'b0, 1'b0, 3'd5, 2'b10, 4'd1);
        step();
        chk("R2 back to direct", dout0, 12'h064);
        cfg(1'b0, 1'b1, 3'd5, 2'b10, 4'd1);
        fire(8'h20, 2'b00);
        chk("R11 enable off clears counter", dout0, 12'h064);
        cfg(1'b0, 1'b1, 3'd5, 2'b01, 4'd1);
        fire(8'h20, 2'b00);
        chk("R12 wave 01 first", dout0, 12'h064);
        fire(8'h20, 2'b00);
        chk("R12 wave 01 second", dout0, 12'h064);

        // R10 wrap
        cfg(1'b0, 1'b1, 3'd5, 2'b10, 4'd3);
        write_hold(2'd0, 32'h0455_0FFD);
        for (int k = 0; k < 6; k++) begin
            fire(8'h20, 2'b00);
            chk("R10 modulo 4096", dout0, 12'(12'hFFD + k));
        end

        // R9 clamp on channel 1 via software strobe
        cfg(1'b1, 1'b1, 3'd2, 2'b10, 4'd12);
        write_hold(2'd0, 32'h0000_0FFD);
        for (int k = 0; k <= 4096; k++) begin
            fire(8'h00, 2'b10);
            if (k == 2)    chk("R9 early step", dout1, 12'd2);
            if (k == 4095) chk("R9 peak 4095", dout1, 12'd4095);
            if (k == 4096) chk("R9 turns down after 4095", dout1, 12'd4094);
        end

        // R1 reset mid-run
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R1 mid-run reset ch0", dout0, 12'h000);
        chk("R1 mid-run reset ch1", dout1, 12'h000);
        write_hold(2'd0, 32'h0010_0020);
        step();
        chk("R1 settings cleared to direct ch0", dout0, 12'h020);
        chk("R1 settings cleared to direct ch1", dout1, 12'h010);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule